// File: doc/BRIEF.md
# Load Queue with Memory-Order Violation Detection

This block tracks the loads that an out-of-order core has dispatched but not yet retired, and keeps them in program order. Each load carries a sequence number. Once its address generation finishes, it also carries an effective address. At dispatch the block hands out a free slot index. It drops loads from the oldest end at commit and from the youngest end on a squash. It also keeps a registered count of the loads that are marked ready to issue.

When a store's address resolves, the block looks for loads that are younger than the store, already have an address, and fall in the same 256-byte address block. If it finds any, it records the oldest of them as the memory-order violator and raises a fault pulse for that store. One violator is held at a time, and no further store is searched until the held violator has been read out. The block also holds a flag for a blocked load, which is cleared by a squash that reaches back past that load.

Top module: `lq_load_queue`

## Requirements
- R1: After reset the queue is empty (q_empty=1, q_full=0), ins_slot=0, rdy_count=0, and viol_valid, st_fault, err and blk_pending are all 0.
- R2: Slot indices are granted from a FIFO of free indices, which holds 0,1,...,DEPTH-1 in that order after reset. Freed indices join its back in removal order: oldest first on commit, youngest first on squash. ins_slot shows the index the next insert will take.
- R3: A commit removes, oldest first, every load whose sequence number is less than or equal to cmt_seq. It stops at the first load that is younger.
- R4: A squash removes, youngest first, every load whose sequence number is greater than sq_seq.
- R5: One queue operation happens per cycle, with priority squash, then commit, then insert. A lower-priority request in the same cycle is dropped.
- R6: q_full is 1 when DEPTH loads are held and q_empty is 1 when none are held. An insert while full, or a commit while empty, changes nothing and sets err to 1 for the following cycle.
- R7: A store (st_valid) is checked against loads with a sequence number strictly greater than st_seq whose address bits [63:8] equal st_addr[63:8]. The oldest such load is latched into viol_slot and viol_seq with viol_valid=1, and st_fault is 1 in the cycle after the store.
- R8: A load with no address written yet, or with a sequence number less than or equal to the store's, never matches.
- R9: While viol_valid is 1, stores are not searched: st_fault stays 0 and the latched violator does not change.
- R10: viol_rd while viol_valid=1 clears viol_valid at the next edge. The identity of the violator is visible until then.
- R11: rdy_count equals the number of held loads whose ready flag is set, and it lags a change of those flags by one cycle.
- R12: blk_set records blk_seq and sets blk_pending. A squash with sq_seq strictly less than the recorded value clears blk_pending, and any other squash leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a load |
| ins_seq | input | 16 | Sequence number of the inserted load |
| ins_slot | output | 3 | Slot index the next insert receives |
| q_full | output | 1 | DEPTH loads held |
| q_empty | output | 1 | No loads held |
| agen_valid | input | 1 | Write a load's effective address |
| agen_slot | input | 3 | Slot receiving the address |
| agen_addr | input | 64 | Effective address |
| rdy_valid | input | 1 | Write a load's ready flag |
| rdy_slot | input | 3 | Slot whose ready flag is written |
| rdy_flag | input | 1 | New ready flag value |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | 16 | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 16 | Loads younger than this are discarded |
| st_valid | input | 1 | A store address has resolved |
| st_seq | input | 16 | Store sequence number |
| st_addr | input | 64 | Store effective address |
| st_fault | output | 1 | Pulse: the previous cycle's store found a violator |
| viol_valid | output | 1 | A violator is latched |
| viol_slot | output | 3 | Slot of the latched violator |
| viol_seq | output | 16 | Sequence number of the latched violator |
| viol_rd | input | 1 | Read and clear the latched violator |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | 16 | Sequence number of the blocked load |
| blk_pending | output | 1 | A blocked load is recorded |
| rdy_count | output | 4 | Number of held loads marked ready |
| err | output | 1 | Pulse: insert while full or commit while empty |

## Verification
The bench aims at the equal-sequence and older-load cases that must not trip the search, at a load with no address yet sitting in a matching block (address register still zero), and at two younger matches where only the older may be reported. A design that compared sequence numbers with "greater or equal", or ignored the address-known flag, would raise faults the scoreboard never expected. A design that scanned from the young end would report the wrong slot. Further stimuli cover the order in which a squash and a commit return indices to the free FIFO, a squash and commit arriving together, a commit that coincides with an insert, and a store arriving while a violator is held. A wrong priority, a reversed push order or a search that is not blocked shows up as a wrong ins_slot, a wrong rdy_count, or a fault that should not have happened.

// File: rtl/lq_pkg.sv
package lq_pkg;

    localparam int LQ_SEQ_W  = 16;
    localparam int LQ_ADDR_W = 64;

    typedef logic [LQ_SEQ_W-1:0]  seq_t;
    typedef logic [LQ_ADDR_W-1:0] addr_t;

    // one queue-changing operation per cycle, highest priority first
    typedef enum logic [1:0] {
        OP_IDLE,
        OP_SQUASH,
        OP_COMMIT,
        OP_INSERT
    } lq_op_e;

    function automatic lq_op_e pick_op(input logic sq, input logic cm,
                                       input logic in, input logic full,
                                       input logic empty);
        if (sq)                return OP_SQUASH;
        else if (cm)           return empty ? OP_IDLE : OP_COMMIT;
        else if (in && !full)  return OP_INSERT;
        else                   return OP_IDLE;
    endfunction

    // true when the load is strictly younger than the store
    function automatic logic is_younger(input seq_t ld, input seq_t st);
        return ld > st;
    endfunction

endpackage

// File: rtl/lq_free_list.sv
module lq_free_list
    import lq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pop,
    output logic [IDX_W-1:0]            head_idx,
    input  logic [CNT_W-1:0]            push_cnt,
    input  logic [DEPTH-1:0][IDX_W-1:0] push_list
);

    logic [IDX_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0] rd_q;
    logic [IDX_W-1:0] wr_q;

    assign head_idx = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= IDX_W'(i);
            end
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            if (pop) begin
                rd_q <= rd_q + IDX_W'(1);
            end
            if (push_cnt != '0) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) < push_cnt) begin
                        mem_q[IDX_W'(wr_q + IDX_W'(i))] <= push_list[i];
                    end
                end
                wr_q <= wr_q + IDX_W'(push_cnt);
            end
        end
    end

endmodule

// File: rtl/lq_viol_search.sv
module lq_viol_search
    import lq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int BLK_W = 56
) (
    input  logic [DEPTH-1:0]            pos_live,
    input  logic [DEPTH-1:0]            pos_aok,
    input  seq_t [DEPTH-1:0]            pos_seq,
    input  logic [DEPTH-1:0][BLK_W-1:0] pos_blk,
    input  seq_t                        st_seq,
    input  logic [BLK_W-1:0]            st_blk,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_pos
);

    logic [DEPTH-1:0] match;

    genvar p;
    generate
        for (p = 0; p < DEPTH; p++) begin : g_cmp
            assign match[p] = pos_live[p] && pos_aok[p] &&
                              is_younger(pos_seq[p], st_seq) &&
                              (pos_blk[p] == st_blk);
        end
    endgenerate

    // position 0 is the oldest: scanning downward leaves the oldest match
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_pos = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lq_ready_count.sv
module lq_ready_count #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] flags,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sum = sum + CNT_W'(flags[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= sum;
    end

endmodule

// File: rtl/lq_load_queue.sv
module lq_load_queue
    import lq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int BLK_SHIFT = 8,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int BLK_W    = LQ_ADDR_W - BLK_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  seq_t             ins_seq,
    output logic [IDX_W-1:0] ins_slot,
    output logic             q_full,
    output logic             q_empty,
    input  logic             agen_valid,
    input  logic [IDX_W-1:0] agen_slot,
    input  addr_t            agen_addr,
    input  logic             rdy_valid,
    input  logic [IDX_W-1:0] rdy_slot,
    input  logic             rdy_flag,
    input  logic             cmt_valid,
    input  seq_t             cmt_seq,
    input  logic             sq_valid,
    input  seq_t             sq_seq,
    input  logic             st_valid,
    input  seq_t             st_seq,
    input  addr_t            st_addr,
    output logic             st_fault,
    output logic             viol_valid,
    output logic [IDX_W-1:0] viol_slot,
    output seq_t             viol_seq,
    input  logic             viol_rd,
    input  logic             blk_set,
    input  seq_t             blk_seq,
    output logic             blk_pending,
    output logic [CNT_W-1:0] rdy_count,
    output logic             err
);

    // per-slot state
    logic [DEPTH-1:0] used_q;
    logic [DEPTH-1:0] aok_q;
    logic [DEPTH-1:0] ready_q;
    seq_t             seq_q  [DEPTH];
    addr_t            addr_q [DEPTH];

    // program-order ring of slot indices
    logic [IDX_W-1:0] ord_q [DEPTH];
    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] tail_ptr;

    seq_t             blk_seq_q;

    // position views, oldest first and youngest first
    logic [DEPTH-1:0][IDX_W-1:0] pos_slot;
    logic [DEPTH-1:0]            pos_live;
    logic [DEPTH-1:0]            pos_aok;
    seq_t [DEPTH-1:0]            pos_seq;
    logic [DEPTH-1:0][BLK_W-1:0] pos_blk;
    logic [DEPTH-1:0][IDX_W-1:0] yng_slot;
    logic [DEPTH-1:0]            yng_live;
    seq_t [DEPTH-1:0]            yng_seq;

    lq_op_e                      op;
    logic [CNT_W-1:0]            n_cmt;
    logic [CNT_W-1:0]            n_sq;
    logic [CNT_W-1:0]            push_cnt;
    logic [DEPTH-1:0][IDX_W-1:0] push_list;
    logic [IDX_W-1:0]            free_head;
    logic                        hit;
    logic [IDX_W-1:0]            hit_pos;

    assign q_full   = (cnt_q == CNT_W'(DEPTH));
    assign q_empty  = (cnt_q == '0);
    assign ins_slot = free_head;
    assign tail_ptr = head_q + IDX_W'(cnt_q);

    assign op = pick_op(sq_valid, cmt_valid, ins_valid, q_full, q_empty);

    genvar p;
    generate
        for (p = 0; p < DEPTH; p++) begin : g_pos
            localparam logic [IDX_W-1:0] OFS = IDX_W'(p);
            localparam logic [IDX_W-1:0] BCK = IDX_W'(p + 1);
            assign pos_slot[p] = ord_q[IDX_W'(head_q + OFS)];
            assign pos_live[p] = (CNT_W'(p) < cnt_q);
            assign pos_aok[p]  = aok_q[pos_slot[p]];
            assign pos_seq[p]  = seq_q[pos_slot[p]];
            assign pos_blk[p]  = addr_q[pos_slot[p]][LQ_ADDR_W-1:BLK_SHIFT];
            assign yng_slot[p] = ord_q[IDX_W'(tail_ptr - BCK)];
            assign yng_live[p] = (CNT_W'(p) < cnt_q);
            assign yng_seq[p]  = seq_q[yng_slot[p]];
        end
    endgenerate

    // length of the committable run from the oldest end
    always_comb begin : c_cmt
        logic stop;
        stop  = 1'b0;
        n_cmt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!stop && pos_live[i] && (pos_seq[i] <= cmt_seq)) begin
                n_cmt = n_cmt + CNT_W'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end

    // length of the squashable run from the youngest end
    always_comb begin : c_sq
        logic stop;
        stop = 1'b0;
        n_sq = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!stop && yng_live[i] && (yng_seq[i] > sq_seq)) begin
                n_sq = n_sq + CNT_W'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end

    always_comb begin
        push_cnt  = '0;
        push_list = pos_slot;
        case (op)
            OP_COMMIT: begin
                push_cnt  = n_cmt;
                push_list = pos_slot;
            end
            OP_SQUASH: begin
                push_cnt  = n_sq;
                push_list = yng_slot;
            end
            default: ;
        endcase
    end

    lq_free_list #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_free (
        .clk       (clk),
        .rst       (rst),
        .pop       (op == OP_INSERT),
        .head_idx  (free_head),
        .push_cnt  (push_cnt),
        .push_list (push_list)
    );

    lq_viol_search #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .BLK_W (BLK_W)
    ) u_search (
        .pos_live (pos_live),
        .pos_aok  (pos_aok),
        .pos_seq  (pos_seq),
        .pos_blk  (pos_blk),
        .st_seq   (st_seq),
        .st_blk   (st_addr[LQ_ADDR_W-1:BLK_SHIFT]),
        .hit      (hit),
        .hit_pos  (hit_pos)
    );

    lq_ready_count #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_rdy (
        .clk   (clk),
        .rst   (rst),
        .flags (used_q & ready_q),
        .count (rdy_count)
    );

    // queue state
    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            cnt_q   <= '0;
            used_q  <= '0;
            aok_q   <= '0;
            ready_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ord_q[i]  <= '0;
                seq_q[i]  <= '0;
                addr_q[i] <= '0;
            end
        end else begin
            if (agen_valid && used_q[agen_slot]) begin
                addr_q[agen_slot] <= agen_addr;
                aok_q[agen_slot]  <= 1'b1;
            end
            if (rdy_valid && used_q[rdy_slot]) begin
                ready_q[rdy_slot] <= rdy_flag;
            end
            case (op)
                OP_SQUASH: begin
                    cnt_q <= cnt_q - n_sq;
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CNT_W'(i) < n_sq) used_q[yng_slot[i]] <= 1'b0;
                    end
                end
                OP_COMMIT: begin
                    head_q <= head_q + IDX_W'(n_cmt);
                    cnt_q  <= cnt_q - n_cmt;
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CNT_W'(i) < n_cmt) used_q[pos_slot[i]] <= 1'b0;
                    end
                end
                OP_INSERT: begin
                    ord_q[tail_ptr]    <= free_head;
                    used_q[free_head]  <= 1'b1;
                    aok_q[free_head]   <= 1'b0;
                    ready_q[free_head] <= 1'b0;
                    seq_q[free_head]   <= ins_seq;
                    cnt_q              <= cnt_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // violator latch, error pulse, blocked-load record
    always_ff @(posedge clk) begin
        if (rst) begin
            viol_valid  <= 1'b0;
            viol_slot   <= '0;
            viol_seq    <= '0;
            st_fault    <= 1'b0;
            err         <= 1'b0;
            blk_pending <= 1'b0;
            blk_seq_q   <= '0;
        end else begin
            st_fault <= 1'b0;
            if (viol_valid) begin
                if (viol_rd) viol_valid <= 1'b0;
            end else if (st_valid && hit) begin
                viol_valid <= 1'b1;
                viol_slot  <= pos_slot[hit_pos];
                viol_seq   <= pos_seq[hit_pos];
                st_fault   <= 1'b1;
            end
            err <= (ins_valid && q_full) || (cmt_valid && q_empty);
            if (blk_set) begin
                blk_pending <= 1'b1;
                blk_seq_q   <= blk_seq;
            end else if (sq_valid && blk_pending && (sq_seq < blk_seq_q)) begin
                blk_pending <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lq_checker.sv
module lq_checker
    import lq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             cmt_valid,
    input logic             q_full,
    input logic             q_empty,
    input logic             st_fault,
    input logic             viol_valid,
    input logic             viol_rd,
    input seq_t             viol_seq,
    input logic [IDX_W-1:0] viol_slot,
    input logic [CNT_W-1:0] rdy_count,
    input logic             err,
    input logic             blk_set,
    input logic             blk_pending
);

    AST_FAULT_HAS_VIOL: assert property (@(posedge clk) disable iff (rst)
        st_fault |-> viol_valid);                                        // R7

    AST_VIOL_HELD: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && !viol_rd) |=> (viol_valid && $stable(viol_seq) && $stable(viol_slot))); // R9

    AST_NO_FAULT_PENDING: assert property (@(posedge clk) disable iff (rst)
        viol_valid |=> !st_fault);                                       // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && viol_rd) |=> !viol_valid);                        // R10

    AST_FULL_ERR: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && q_full) |=> err);                                  // R6

    AST_EMPTY_ERR: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && q_empty) |=> err);                                 // R6

    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_empty));                                           // R6

    AST_EMPTY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        q_empty |=> (rdy_count == '0));                                  // R11

    AST_BLK_SET: assert property (@(posedge clk) disable iff (rst)
        blk_set |=> blk_pending);                                        // R12

endmodule

bind lq_load_queue lq_checker #(.DEPTH(DEPTH)) u_lq_checker (
    .clk         (clk),
    .rst         (rst),
    .ins_valid   (ins_valid),
    .cmt_valid   (cmt_valid),
    .q_full      (q_full),
    .q_empty     (q_empty),
    .st_fault    (st_fault),
    .viol_valid  (viol_valid),
    .viol_rd     (viol_rd),
    .viol_seq    (viol_seq),
    .viol_slot   (viol_slot),
    .rdy_count   (rdy_count),
    .err         (err),
    .blk_set     (blk_set),
    .blk_pending (blk_pending)
);

// File: tb/tb_lq_load_queue.sv
`timescale 1ns/1ps
module tb_lq_load_queue;
    import lq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 0;
    seq_t        ins_seq = '0;
    logic [2:0]  ins_slot;
    logic        q_full, q_empty;
    logic        agen_valid = 0;
    logic [2:0]  agen_slot = '0;
    addr_t       agen_addr = '0;
    logic        rdy_valid = 0;
    logic [2:0]  rdy_slot = '0;
    logic        rdy_flag = 0;
    logic        cmt_valid = 0;
    seq_t        cmt_seq = '0;
    logic        sq_valid = 0;
    seq_t        sq_seq = '0;
    logic        st_valid = 0;
    seq_t        st_seq = '0;
    addr_t       st_addr = '0;
    logic        st_fault, viol_valid;
    logic [2:0]  viol_slot;
    seq_t        viol_seq;
    logic        viol_rd = 0;
    logic        blk_set = 0;
    seq_t        blk_seq = '0;
    logic        blk_pending;
    logic [3:0]  rdy_count;
    logic        err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    int exp_seq_q[$];
    int exp_slot_q[$];

    always #4 clk = ~clk;   // 125 MHz

    lq_load_queue dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_slot(ins_slot),
        .q_full(q_full), .q_empty(q_empty),
        .agen_valid(agen_valid), .agen_slot(agen_slot), .agen_addr(agen_addr),
        .rdy_valid(rdy_valid), .rdy_slot(rdy_slot), .rdy_flag(rdy_flag),
        .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr),
        .st_fault(st_fault), .viol_valid(viol_valid), .viol_slot(viol_slot),
        .viol_seq(viol_seq), .viol_rd(viol_rd),
        .blk_set(blk_set), .blk_seq(blk_seq), .blk_pending(blk_pending),
        .rdy_count(rdy_count), .err(err)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic do_insert(input int seq);
        ins_valid = 1; ins_seq = seq_t'(seq);
        cyc();
        ins_valid = 0;
    endtask

    task automatic do_agen(input int slot, input longint addr);
        agen_valid = 1; agen_slot = 3'(slot); agen_addr = addr_t'(addr);
        cyc();
        agen_valid = 0;
    endtask

    task automatic do_ready(input int slot);
        rdy_valid = 1; rdy_slot = 3'(slot); rdy_flag = 1;
        cyc();
        rdy_valid = 0;
    endtask

    // insert, check the granted slot, then mark it ready
    task automatic ins_rdy(input int seq, input int exp_slot);
        int s;
        s = int'(ins_slot);
        chk("R2 granted slot", s, exp_slot);
        do_insert(seq);
        do_ready(s);
    endtask

    // driver: pushes the expected violator into the scoreboard
    task automatic do_store(input int seq, input longint addr, input bit exp_hit,
                            input int e_seq, input int e_slot, input string tag);
        if (exp_hit) begin
            exp_seq_q.push_back(e_seq);
            exp_slot_q.push_back(e_slot);
        end
        st_valid = 1; st_seq = seq_t'(seq); st_addr = addr_t'(addr);
        cyc();
        st_valid = 0;
        chk({tag, " fault flag"}, st_fault, exp_hit);
    endtask

    task automatic do_read();
        viol_rd = 1;
        cyc();
        viol_rd = 0;
        chk("R10 viol cleared by read", viol_valid, 0);
    endtask

    // monitor: compares each reported violator with the scoreboard
    always @(negedge clk) begin
        if (!rst && st_fault) begin
            if (exp_seq_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R7 unexpected violator actual=%0d expected=none", viol_seq);
            end else begin
                chk("R7 violator seq", viol_seq, exp_seq_q.pop_front());
                chk("R7 violator slot", viol_slot, exp_slot_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        chk("R1 empty", q_empty, 1);
        chk("R1 full", q_full, 0);
        chk("R1 ins_slot", ins_slot, 0);
        chk("R1 rdy_count", rdy_count, 0);
        chk("R1 viol_valid", viol_valid, 0);
        chk("R1 err", err, 0);
        chk("R1 blk_pending", blk_pending, 0);

        // R2 grants in index order after reset
        chk("R2 slot", ins_slot, 0); do_insert(10);
        chk("R2 slot", ins_slot, 1); do_insert(20);
        chk("R2 slot", ins_slot, 2); do_insert(30);
        chk("R2 slot", ins_slot, 3);
        do_agen(0, 64'h1000);
        do_agen(1, 64'h1080);
        do_agen(2, 64'h2000);

        // R11 one-cycle lag of the ready count
        do_ready(0);
        chk("R11 count lags", rdy_count, 0);
        cyc();
        chk("R11 count", rdy_count, 1);
        do_ready(1);
        do_ready(2);
        cyc();
        chk("R11 count three", rdy_count, 3);

        // R7 oldest younger load in the same block
        do_store(5, 64'h10FF, 1, 10, 0, "R7");
        chk("R7 viol_valid", viol_valid, 1);
        // R9 pending violator blocks the next search
        do_store(15, 64'h2000, 0, 0, 0, "R9");
        chk("R9 violator held", viol_seq, 10);
        do_read();

        // R8 equal sequence number is not younger
        do_store(10, 64'h1000, 1, 20, 1, "R8");
        do_read();

        // R8 load without address, and older load in the block
        chk("R2 slot", ins_slot, 3); do_insert(40);
        do_store(35, 64'h0, 0, 0, 0, "R8 no address");
        do_store(35, 64'h2000, 0, 0, 0, "R8 older load");

        // R4 squash 25 removes 40 (slot 3) then 30 (slot 2)
        sq_valid = 1; sq_seq = 25; cyc(); sq_valid = 0;
        cyc();
        chk("R4 ready after squash", rdy_count, 2);
        // R3 commit 15 removes seq 10 only
        cmt_valid = 1; cmt_seq = 15; cyc(); cmt_valid = 0;
        cyc();
        chk("R3 ready after commit", rdy_count, 1);
        chk("R3 not empty", q_empty, 0);

        // R2 freed order: 4,5,6,7 then 3,2 (squash) then 0 (commit)
        ins_rdy(50, 4); ins_rdy(60, 5); ins_rdy(70, 6); ins_rdy(80, 7);
        ins_rdy(90, 3); ins_rdy(100, 2); ins_rdy(110, 0);
        cyc();
        chk("R6 full", q_full, 1);
        chk("R11 count eight", rdy_count, 8);

        // R6 insert while full
        do_insert(120);
        chk("R6 err on full insert", err, 1);
        chk("R6 still full", q_full, 1);
        cyc();
        chk("R6 err is a pulse", err, 0);

        // R5 squash beats commit
        sq_valid = 1; sq_seq = 100; cmt_valid = 1; cmt_seq = 200;
        cyc(); sq_valid = 0; cmt_valid = 0;
        cyc();
        chk("R5 only squash applied", rdy_count, 7);
        chk("R5 freed slot", ins_slot, 0);

        // R5 commit beats insert; R3 commit 60 removes 20,50,60
        cmt_valid = 1; cmt_seq = 60; ins_valid = 1; ins_seq = 130;
        cyc(); cmt_valid = 0; ins_valid = 0;
        chk("R5 insert dropped", ins_slot, 0);
        cyc();
        chk("R3 ready after commit", rdy_count, 4);

        // R7 two younger matches: oldest (80, slot 7) reported
        do_agen(7, 64'h3300);
        do_agen(3, 64'h3310);
        do_store(75, 64'h33AA, 1, 80, 7, "R7 oldest");
        do_read();

        // R6 commit while empty
        cmt_valid = 1; cmt_seq = 1000; cyc(); cmt_valid = 0;
        chk("R3 all committed", q_empty, 1);
        cmt_valid = 1; cyc(); cmt_valid = 0;
        chk("R6 err on empty commit", err, 1);

        // R12 blocked-load record
        blk_set = 1; blk_seq = 500; cyc(); blk_set = 0;
        chk("R12 set", blk_pending, 1);
        sq_valid = 1; sq_seq = 600; cyc(); sq_valid = 0;
        chk("R12 younger squash keeps", blk_pending, 1);
        sq_valid = 1; sq_seq = 400; cyc(); sq_valid = 0;
        chk("R12 older squash clears", blk_pending, 0);

        cyc();
        chk("R7 scoreboard drained", exp_seq_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule